// File: doc/BRIEF.md
# Receive Sideband Word Capture Register

This block holds a 32-bit management word that arrives alongside each received frame. A capture port delivers the word together with a one-cycle strobe. A host reads the held value as two 16-bit halves through a small register read port. A valid output tells the host that a meaningful (non-zero) word is waiting.

The host first reads the low half. That read freezes the register, so frames that arrive while the host is busy cannot change the value it is halfway through reading. The host then reads the high half. That read clears the valid flag and re-opens the register for new captures. Any word that is thrown away while the register is frozen sets a sticky overrun flag. The overrun flag is reported in a status word, and reading the status word clears it.

A synchronous soft reset clears everything the active-low hardware reset clears.

Top module: `sbw_capture`

## Requirements
- R1: After `rst_n` is low, or in the cycle after `soft_rst` is high, the held word, valid, lock, overrun and `rd_data` are all zero.
- R2: A read strobe with `rd_addr`=0 returns held bits 15:0 on `rd_data`, and `rd_addr`=1 returns bits 31:16. The data appears one cycle after the strobe and is taken from the state before that strobe's effects.
- R3: An accepted capture always stores the word. `valid_o` rises only if the word is non-zero; a zero word leaves `valid_o` unchanged.
- R4: A read of address 0 sets the lock. While locked, capture strobes leave the held word and `valid_o` unchanged.
- R5: A read of address 1 clears `valid_o` and the lock in the next cycle.
- R6: A capture in the same cycle as an address-1 read is accepted: the unlock applies first. `valid_o` is 1 afterwards if that word is non-zero.
- R7: A capture in the same cycle as an address-0 read is dropped. The lock is set and the held word keeps its old value.
- R8: A dropped capture sets a sticky overrun flag. A read of address 2 clears the flag, but a drop in the same cycle wins and keeps it set.
- R9: Address 2 returns a status word: bit 0 is valid, bit 1 is lock, bit 2 is overrun, and all other bits are 0. Address 3 returns 0.
- R10: With no read strobe, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear |
| cap_stb | input | 1 | Capture strobe, one cycle per frame |
| cap_word | input | 32 | Sideband word to capture |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address: 0 low, 1 high, 2 status |
| rd_data | output | 16 | Registered read data |
| valid_o | output | 1 | A non-zero word is waiting |

## Verification
On every cycle, the assertions check the lock, unlock and valid transitions, the freeze of the held word while locked, the setting of overrun, the hold of read data and the effect of soft reset. Data correctness is left to the bench. Which half is returned, what status word is returned, and the ordering cases are shown by directed sequences: zero versus upper-only non-zero words, capture colliding with either read, and overrun set against status-read clear. A long pseudo-random sweep then compares every output with an arithmetic model.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
   typedef struct packed {
      logic ovr;
      logic lock;
      logic valid;
   } sbw_flags_t;

   localparam int STAT_BITS = 3;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_LO   = 2'd1,
      RD_HI   = 2'd2,
      RD_STAT = 2'd3
   } sbw_rd_e;
endpackage

// File: rtl/sbw_hold.sv
module sbw_hold #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= '0;
      else if (soft_rst) held <= '0;
      else if (load)     held <= word_in;
   end
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
   import sbw_pkg::*;
#(
   parameter bit OVR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       cap_stb,
   input  logic       word_nz,
   input  sbw_rd_e    rd_kind,
   output logic       load,
   output sbw_flags_t flags
);
   logic lo_rd, hi_rd, st_rd, drop;
   logic lock_q, valid_q;

   assign lo_rd = (rd_kind == RD_LO);
   assign hi_rd = (rd_kind == RD_HI);
   assign st_rd = (rd_kind == RD_STAT);

   // unlock by a high read applies before capture; a low read blocks capture
   assign load = cap_stb && !lo_rd && (!lock_q || hi_rd);
   assign drop = cap_stb && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (soft_rst) begin
         lock_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (lo_rd)      lock_q <= 1'b1;
         else if (hi_rd) lock_q <= 1'b0;
         if (load && word_nz) valid_q <= 1'b1;
         else if (hi_rd)      valid_q <= 1'b0;
      end
   end

   generate
      if (OVR_EN) begin : g_ovr
         logic ovr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ovr_q <= 1'b0;
            else if (soft_rst) ovr_q <= 1'b0;
            else if (drop)     ovr_q <= 1'b1;
            else if (st_rd)    ovr_q <= 1'b0;
         end
         assign flags.ovr = ovr_q;
      end else begin : g_no_ovr
         logic unused_ovr;
         assign unused_ovr = drop ^ st_rd;
         assign flags.ovr  = 1'b0;
      end
   endgenerate

   assign flags.lock  = lock_q;
   assign flags.valid = valid_q;
endmodule

// File: rtl/sbw_rdport.sv
module sbw_rdport
   import sbw_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rd_stb,
   input  sbw_rd_e           rd_kind,
   input  logic [WORD_W-1:0] held,
   input  sbw_flags_t        flags,
   output logic [HALF_W-1:0] rd_data
);
   logic [HALF_W-1:0] mux;

   always_comb begin
      mux = '0;
      unique case (rd_kind)
         RD_LO:   mux = held[HALF_W-1:0];
         RD_HI:   mux = held[WORD_W-1:HALF_W];
         RD_STAT: mux[STAT_BITS-1:0] = flags;
         default: mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_data <= '0;
      else if (soft_rst) rd_data <= '0;
      else if (rd_stb)   rd_data <= mux;
   end
endmodule

// File: rtl/sbw_capture.sv
module sbw_capture
   import sbw_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int ADDR_LO   = 0,
   parameter int ADDR_HI   = 1,
   parameter int ADDR_STAT = 2,
   parameter bit OVR_EN    = 1'b1,
   localparam int HALF_W   = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cap_stb,
   input  logic [WORD_W-1:0] cap_word,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [HALF_W-1:0] rd_data,
   output logic              valid_o
);
   if (WORD_W % 2 != 0) begin : g_bad_width
      $error("sbw_capture: WORD_W must be even");
   end
   if (HALF_W < STAT_BITS) begin : g_bad_half
      $error("sbw_capture: half word too narrow for status");
   end
   if ((1 << ADDR_W) <= ADDR_STAT || (1 << ADDR_W) <= ADDR_HI || (1 << ADDR_W) <= ADDR_LO) begin : g_bad_addr
      $error("sbw_capture: address out of range");
   end
   if (ADDR_LO == ADDR_HI || ADDR_LO == ADDR_STAT || ADDR_HI == ADDR_STAT) begin : g_dup_addr
      $error("sbw_capture: addresses must differ");
   end

   sbw_rd_e           rd_kind;
   logic              load;
   sbw_flags_t        flags;
   logic [WORD_W-1:0] held_q;

   always_comb begin
      rd_kind = RD_NONE;
      if (rd_stb) begin
         if (rd_addr == ADDR_W'(ADDR_LO))        rd_kind = RD_LO;
         else if (rd_addr == ADDR_W'(ADDR_HI))   rd_kind = RD_HI;
         else if (rd_addr == ADDR_W'(ADDR_STAT)) rd_kind = RD_STAT;
      end
   end

   sbw_ctrl #(.OVR_EN(OVR_EN)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cap_stb(cap_stb), .word_nz(|cap_word), .rd_kind(rd_kind),
      .load(load), .flags(flags)
   );

   sbw_hold #(.WORD_W(WORD_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .load(load), .word_in(cap_word), .held(held_q)
   );

   sbw_rdport #(.WORD_W(WORD_W)) i_rdport (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .rd_stb(rd_stb), .rd_kind(rd_kind), .held(held_q),
      .flags(flags), .rd_data(rd_data)
   );

   assign valid_o = flags.valid;
endmodule

// File: rtl/sbw_capture_chk.sv
module sbw_capture_chk #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int ADDR_LO   = 0,
   parameter int ADDR_HI   = 1,
   parameter bit OVR_EN    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              cap_stb,
   input logic [WORD_W-1:0] cap_word,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [WORD_W/2-1:0] rd_data,
   input logic              valid_o,
   input logic              lock,
   input logic              ovr,
   input logic [WORD_W-1:0] held
);
   logic lo_rd, hi_rd;
   assign lo_rd = rd_stb && (rd_addr == ADDR_W'(ADDR_LO));
   assign hi_rd = rd_stb && (rd_addr == ADDR_W'(ADDR_HI));

   // R1
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (rd_data == '0) && !valid_o && !lock && !ovr && (held == '0));

   // R3
   nz_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb && !lock && !lo_rd && !soft_rst && (cap_word != '0) |=> valid_o);

   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock && !hi_rd && !soft_rst |=> $stable(held) && lock);

   // R5
   hi_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd && !cap_stb && !soft_rst |=> !valid_o && !lock);

   // R6
   hi_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd && cap_stb && (cap_word != '0) && !soft_rst |=> valid_o && !lock);

   // R7
   lo_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd && !soft_rst |=> lock && $stable(held));

   // R8
   drop_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      OVR_EN && cap_stb && (lock || lo_rd) && !hi_rd && !soft_rst |=> ovr);

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb && !soft_rst |=> $stable(rd_data));
endmodule

bind sbw_capture sbw_capture_chk #(
   .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO),
   .ADDR_HI(ADDR_HI), .OVR_EN(OVR_EN)
) i_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cap_stb(cap_stb),
   .cap_word(cap_word), .rd_stb(rd_stb), .rd_addr(rd_addr),
   .rd_data(rd_data), .valid_o(valid_o), .lock(flags.lock),
   .ovr(flags.ovr), .held(held_q)
);

// File: tb/test_sbw_capture.sv
module test_sbw_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        cap_stb = 1'b0;
   logic [31:0] cap_word = '0;
   logic        rd_stb = 1'b0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        valid_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model state
   logic [31:0] m_word;
   logic m_valid, m_lock, m_ovr;
   logic [15:0] m_rd;

   always #5 clk = ~clk;

   sbw_capture i_sbw_capture (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cap_stb(cap_stb),
      .cap_word(cap_word), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_data(rd_data), .valid_o(valid_o)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_word = '0; m_valid = 1'b0; m_lock = 1'b0; m_ovr = 1'b0; m_rd = '0;
   endtask

   // one cycle: drive at negedge, model at posedge, compare at next negedge
   task automatic step(input logic cap, input logic [31:0] w, input logic rd,
                       input logic [1:0] a, input string tag);
      logic lo, hi, st, ok;
      cap_stb = cap; cap_word = w; rd_stb = rd; rd_addr = a;
      @(posedge clk);
      lo = rd && a == 2'd0; hi = rd && a == 2'd1; st = rd && a == 2'd2;
      if (rd) begin
         case (a)
            2'd0: m_rd = m_word[15:0];
            2'd1: m_rd = m_word[31:16];
            2'd2: m_rd = {13'd0, m_ovr, m_lock, m_valid};
            default: m_rd = '0;
         endcase
      end
      ok = cap && !lo && (!m_lock || hi);
      if (ok) m_word = w;
      if (ok && w != 0) m_valid = 1'b1;
      else if (hi) m_valid = 1'b0;
      if (lo) m_lock = 1'b1;
      else if (hi) m_lock = 1'b0;
      if (cap && !ok) m_ovr = 1'b1;
      else if (st) m_ovr = 1'b0;
      @(negedge clk);
      cap_stb = 1'b0; rd_stb = 1'b0;
      chk(rd_data, m_rd, {tag, " rd_data"});
      chk(valid_o, m_valid, {tag, " valid"});
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      step(1'b0, 32'h0, 1'b1, a, tag);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk(rd_data, 16'h0, "R1 reset rd_data");
      chk(valid_o, 1'b0, "R1 reset valid");
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1, "R1 reset high"); chk(rd_data, 16'h0, "R1 high zero");
      rd(2'd2, "R1 reset status"); chk(rd_data, 16'h0, "R1 status zero");

      // capture, read low, locked drop, read high
      step(1'b1, 32'hA5A5_1234, 1'b0, 2'd0, "R3 capture");
      chk(valid_o, 1'b1, "R3 nonzero sets valid");
      rd(2'd0, "R2 low"); chk(rd_data, 16'h1234, "R2 low half");
      step(1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, "R4 locked capture");
      rd(2'd2, "R9 status"); chk(rd_data, 16'h0007, "R9 status valid|lock|ovr");
      rd(2'd2, "R8 status again"); chk(rd_data, 16'h0003, "R8 overrun cleared");
      rd(2'd1, "R2 high"); chk(rd_data, 16'hA5A5, "R4 held high half");
      chk(valid_o, 1'b0, "R5 valid cleared");
      rd(2'd2, "R5 status"); chk(rd_data, 16'h0000, "R5 unlocked");
      rd(2'd3, "R9 addr3"); chk(rd_data, 16'h0000, "R9 unmapped zero");

      // zero word: stored, no valid
      step(1'b1, 32'h0, 1'b0, 2'd0, "R3 zero capture");
      chk(valid_o, 1'b0, "R3 zero no valid");
      rd(2'd1, "R3 zero stored"); chk(rd_data, 16'h0000, "R3 zero stored high");
      step(1'b1, 32'h0001_0000, 1'b0, 2'd0, "R3 upper only");
      chk(valid_o, 1'b1, "R3 upper-only nonzero");

      // lock then capture with high read
      rd(2'd0, "R6 lock"); chk(rd_data, 16'h0000, "R2 low zero");
      step(1'b1, 32'h0000_BEEF, 1'b1, 2'd1, "R6 cap+hi");
      chk(valid_o, 1'b1, "R6 valid after cap+hi");
      chk(rd_data, 16'h0001, "R6 high returns old");
      rd(2'd0, "R6 new word"); chk(rd_data, 16'hBEEF, "R6 new word stored");

      // capture with low read dropped; overrun set wins over status clear not same cycle
      rd(2'd1, "R7 unlock");
      step(1'b1, 32'h1111_2222, 1'b1, 2'd0, "R7 cap+lo");
      chk(rd_data, 16'hBEEF, "R7 low returns old");
      rd(2'd1, "R7 high"); chk(rd_data, 16'h0000, "R7 word kept");
      rd(2'd0, "R8 relock");
      step(1'b1, 32'h5, 1'b1, 2'd2, "R8 drop+status");
      chk(rd_data, 16'h0006, "R8 status pre-drop");
      rd(2'd2, "R8 set wins"); chk(rd_data, 16'h0006, "R8 overrun kept");

      // R10 hold
      repeat (3) @(negedge clk);
      chk(rd_data, 16'h0006, "R10 rd_data held");

      // soft reset
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      model_reset();
      chk(rd_data, 16'h0, "R1 soft rd_data");
      chk(valid_o, 1'b0, "R1 soft valid");
      rd(2'd2, "R1 soft status"); chk(rd_data, 16'h0, "R1 soft flags");

      // pseudo-random sweep against model
      begin
         logic [15:0] lf = 16'hACE1;
         logic [31:0] w;
         for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[7:6])
               2'd0: w = 32'h0;
               2'd1: w = 32'h8000_0000;
               2'd2: w = 32'h0000_0001;
               default: w = {lf, ~lf};
            endcase
            step(lf[0], w, lf[1] | lf[2], lf[4:3], "sweep R2 R3 R4 R8");
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule